// File: doc/BRIEF.md
# Frame Queue With Wrapping Level Field

This block is an eight-entry first-in first-out store for 9-bit frames. It serves one direction of a serial link: the transmit path or the receive path. One side pushes frames with a single-cycle request. The other side reads the oldest frame straight from the head entry and removes it with a pop request.

The block publishes a fill-level field that is only as wide as the pointer, which is 3 bits at the default depth. When every entry is occupied this field reads 0, so a full queue differs from an empty one only in the separate full flag. Empty and half flags are also provided.

A synchronous flush discards every entry in one cycle. The block keeps three sticky error flags:
- overflow: a push arrived while the queue was full.
- underflow: a pop arrived while the queue was empty.
- flush error: a flush threw away frames that had not been read.

A flush also clears the overflow and underflow flags. The flush error stays set until a flush finds the queue already drained.

Top module: `frame_queue`

## Requirements
- R1: Frames leave in the order they were accepted, each 9-bit value intact, and up to 8 frames are held at once.
- R2: pop_data always shows the oldest stored frame with no added latency. A frame pushed into an empty queue is visible on pop_data in the cycle after the push edge, without any pop.
- R3: level equals the occupancy modulo 8 (3 bits). It reads 0 both when the queue is empty and when it holds exactly 8 frames.
- R4: full is 1 exactly when 8 frames are held, and empty is 1 exactly when none is held.
- R5: half is 1 whenever the occupancy is 4 or more, and 0 below 4.
- R6: A push while full is refused. The contents and occupancy are unchanged and overflow becomes 1 and stays 1.
- R7: A pop while empty is refused and sets underflow, which stays 1. A push in the same cycle is still accepted.
- R8: A push and a pop in the same cycle, with neither refused, are both carried out and the occupancy stays the same. When full, a simultaneous push is refused (overflow) while the pop is carried out.
- R9: Flush empties the queue at the next edge. A push or pop in the flush cycle has no effect and sets no sticky flag.
- R10: A flush while frames are held sets flush_err and clears overflow and underflow. A flush on an empty queue clears all three.
- R11: After reset: empty=1, full=0, half=0, level=0, and overflow, underflow and flush_err are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous discard of all entries |
| push_req | input | 1 | Push request for push_data |
| push_data | input | 9 | Frame to store |
| pop_req | input | 1 | Remove the head frame |
| pop_data | output | 9 | Head frame, combinational from storage |
| level | output | 3 | Occupancy modulo depth |
| full | output | 1 | All entries occupied |
| half | output | 1 | Occupancy at least half the depth |
| empty | output | 1 | No entries occupied |
| overflow | output | 1 | Sticky: push refused while full |
| underflow | output | 1 | Sticky: pop refused while empty |
| flush_err | output | 1 | Sticky: flush discarded unread frames |

## Verification
The bench builds the block with its default pointer width of 3, which gives a depth of 8 and 9-bit frames. At that size the level field wraps at the very occupancy where full rises, so the 8-entry case and the empty case can be compared directly. The small depth lets a short sequence fill and drain the queue several times, so both pointers wrap repeatedly. It also reaches overflow, underflow and the simultaneous push-and-pop cases at both the full and the empty boundary.

// File: rtl/frame_queue_pkg.sv
package frame_queue_pkg;

  typedef struct packed {
    logic overflow;
    logic underflow;
    logic flush_err;
  } fq_sticky_t;

  typedef enum logic [1:0] {
    FQ_HOLD = 2'd0,
    FQ_INC  = 2'd1,
    FQ_DEC  = 2'd2,
    FQ_CLR  = 2'd3
  } fq_move_e;

  // Decide how the occupancy moves this cycle from the accepted operations.
  function automatic fq_move_e fq_move(input logic push_ok, input logic pop_ok,
                                       input logic flush);
    if (flush)                 return FQ_CLR;
    else if (push_ok && !pop_ok) return FQ_INC;
    else if (pop_ok && !push_ok) return FQ_DEC;
    else                       return FQ_HOLD;
  endfunction

endpackage

// File: rtl/fq_store.sv
module fq_store #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_ptr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_ptr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_ptr == ADDR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   slot[i] <= '0;
      else if (hit) slot[i] <= wr_data;
    end
  end

  // Head entry straight to the output: no read latency.
  assign rd_data = slot[rd_ptr];

endmodule

// File: rtl/fq_ptrs.sv
module fq_ptrs
  import frame_queue_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_ok,
  input  logic              pop_ok,
  input  logic              flush,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic [ADDR_W:0]   count
);
  localparam logic [ADDR_W:0]   CNT_ONE = (ADDR_W+1)'(1);
  localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);
  localparam logic [ADDR_W:0]   DEPTH_C = (ADDR_W+1)'(1 << ADDR_W);

  function automatic logic [ADDR_W-1:0] ptr_step(input logic [ADDR_W-1:0] p);
    return p + PTR_ONE;
  endfunction

  function automatic logic [ADDR_W:0] count_step(input logic [ADDR_W:0] c,
                                                 input fq_move_e mv);
    case (mv)
      FQ_INC:  return c + CNT_ONE;
      FQ_DEC:  return c - CNT_ONE;
      FQ_CLR:  return '0;
      default: return c;
    endcase
  endfunction

  fq_move_e move;
  assign move = fq_move(push_ok, pop_ok, flush);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      count <= count_step(count, move);
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (push_ok) wr_ptr <= ptr_step(wr_ptr);
        if (pop_ok)  rd_ptr <= ptr_step(rd_ptr);
      end
    end
  end

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_C);

  assert_push_grows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok && !flush) |=> (count == $past(count) + CNT_ONE));

  assert_both_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok && !flush) |=> $stable(count));

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0) && (wr_ptr == rd_ptr));

endmodule

// File: rtl/fq_flags.sv
module fq_flags
  import frame_queue_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W:0]   count,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic              flush,
  output logic              push_ok,
  output logic              pop_ok,
  output logic [ADDR_W-1:0] level,
  output logic              full,
  output logic              half,
  output logic              empty,
  output fq_sticky_t        sticky
);
  localparam logic [ADDR_W:0] DEPTH_C = (ADDR_W+1)'(1 << ADDR_W);
  localparam logic [ADDR_W:0] HALF_C  = (ADDR_W+1)'(1 << (ADDR_W-1));

  function automatic logic [ADDR_W-1:0] wrap_level(input logic [ADDR_W:0] c);
    return c[ADDR_W-1:0];
  endfunction

  function automatic logic at_half(input logic [ADDR_W:0] c);
    return c >= HALF_C;
  endfunction

  assign level = wrap_level(count);
  assign full  = (count == DEPTH_C);
  assign empty = (count == '0);
  assign half  = at_half(count);

  // Named events for the assertions.
  logic ovf_evt, unf_evt, lossy_flush;
  assign ovf_evt     = push_req && full  && !flush;
  assign unf_evt     = pop_req  && empty && !flush;
  assign lossy_flush = flush && !empty;
  assign push_ok     = push_req && !full  && !flush;
  assign pop_ok      = pop_req  && !empty && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky <= '0;
    end else if (flush) begin
      sticky.overflow  <= 1'b0;
      sticky.underflow <= 1'b0;
      sticky.flush_err <= lossy_flush;
    end else begin
      if (ovf_evt) sticky.overflow  <= 1'b1;
      if (unf_evt) sticky.underflow <= 1'b1;
    end
  end

  assert_full_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (level == '0) && !empty && half);

  assert_half_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!half) |-> !full && (level < ADDR_W'(1 << (ADDR_W-1))));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> sticky.overflow);

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |=> sticky.underflow);

  assert_refuse_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push_ok);

  assert_flush_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lossy_flush |=> sticky.flush_err && !sticky.overflow && !sticky.underflow);

  assert_clean_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && empty) |=> (sticky == '0));

endmodule

// File: rtl/frame_queue.sv
module frame_queue
  import frame_queue_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] pop_data,
  output logic [ADDR_W-1:0] level,
  output logic              full,
  output logic              half,
  output logic              empty,
  output logic              overflow,
  output logic              underflow,
  output logic              flush_err
);
  logic              push_ok, pop_ok;
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;
  logic [ADDR_W:0]   count;
  fq_sticky_t        sticky;

  fq_flags #(.ADDR_W(ADDR_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .count(count), .push_req(push_req),
    .pop_req(pop_req), .flush(flush), .push_ok(push_ok), .pop_ok(pop_ok),
    .level(level), .full(full), .half(half), .empty(empty), .sticky(sticky)
  );

  fq_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .push_ok(push_ok), .pop_ok(pop_ok),
    .flush(flush), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count)
  );

  fq_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(push_ok), .wr_ptr(wr_ptr),
    .wr_data(push_data), .rd_ptr(rd_ptr), .rd_data(pop_data)
  );

  assign overflow  = sticky.overflow;
  assign underflow = sticky.underflow;
  assign flush_err = sticky.flush_err;

  assert_first_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && push_req && !flush) |=> (pop_data == $past(push_data)));

  assert_empty_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !full && !half && (level == '0));

endmodule

// File: tb/sim_frame_queue.sv
module sim_frame_queue;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0, push_req = 1'b0, pop_req = 1'b0;
  logic [8:0] push_data = '0;
  logic [8:0] pop_data;
  logic [2:0] level;
  logic       full, half, empty, overflow, underflow, flush_err;

  int n_checks = 0;
  int n_fail = 0;
  logic [8:0] m_q[$];
  logic m_ov = 0, m_un = 0, m_fe = 0;

  always #5 clk = ~clk;

  frame_queue u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push_req(push_req),
    .push_data(push_data), .pop_req(pop_req), .pop_data(pop_data),
    .level(level), .full(full), .half(half), .empty(empty),
    .overflow(overflow), .underflow(underflow), .flush_err(flush_err)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: every accepted pop compares the head against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && pop_req && !flush && m_q.size() > 0)
      check("R1 pop order/data", int'(pop_data), int'(m_q[0]));
  end

  // Driver: applies one cycle of stimulus and advances the model.
  task automatic step(input logic ps, input logic [8:0] d, input logic pp,
                      input logic fl);
    bit was_full, was_empty;
    push_req = ps; push_data = d; pop_req = pp; flush = fl;
    @(posedge clk); #1;
    was_full  = (m_q.size() == 8);
    was_empty = (m_q.size() == 0);
    if (fl) begin
      m_fe = !was_empty; m_ov = 0; m_un = 0;
      m_q.delete();
    end else begin
      if (pp) begin
        if (was_empty) m_un = 1; else void'(m_q.pop_front());
      end
      if (ps) begin
        if (was_full) m_ov = 1; else m_q.push_back(d);
      end
    end
    push_req = 0; pop_req = 0; flush = 0;
  endtask

  task automatic check_status(input string tag);
    int n;
    n = m_q.size();
    check({tag, " R3 level"},  int'(level), n % 8);
    check({tag, " R4 full"},   int'(full),  int'(n == 8));
    check({tag, " R4 empty"},  int'(empty), int'(n == 0));
    check({tag, " R5 half"},   int'(half),  int'(n >= 4));
    check({tag, " R6 overflow"},  int'(overflow),  int'(m_ov));
    check({tag, " R7 underflow"}, int'(underflow), int'(m_un));
    check({tag, " R10 flush_err"}, int'(flush_err), int'(m_fe));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check_status("R11 reset");
    // R2: first frame visible without pop
    step(1, 9'h1A5, 0, 0);
    check("R2 head visible", int'(pop_data), 'h1A5);
    check_status("one");
    for (int i = 0; i < 2; i++) step(1, 9'(9'h010 + i), 0, 0);
    check_status("three");
    step(1, 9'h0FF, 0, 0);
    check_status("R5 four");
    for (int i = 0; i < 4; i++) step(1, 9'(9'h100 | (i * 37)), 0, 0);
    check_status("R3 eight wraps");
    // R6 push while full
    step(1, 9'h000, 0, 0);
    check_status("R6 push full");
    // R8 at full: pop taken, push refused
    step(1, 9'h055, 1, 0);
    check_status("R8 both at full");
    for (int i = 0; i < 7; i++) step(0, '0, 1, 0);
    check_status("R1 drained");
    // R7 pop on empty, with a push in the same cycle
    step(0, '0, 1, 0);
    check_status("R7 pop empty");
    step(1, 9'h133, 1, 0);
    check_status("R7 push with pop empty");
    check("R7 pushed frame", int'(pop_data), 'h133);
    step(1, 9'h044, 0, 0);
    step(1, 9'h1FE, 0, 0);
    // R8 simultaneous push and pop, many cycles, pointers wrap
    for (int i = 0; i < 20; i++) begin
      step(1, 9'((i * 53) ^ 9'h0AA), 1, 0);
      check("R8 level steady", int'(level), 3);
    end
    check_status("R8 stream");
    // R9/R10 lossy flush with push/pop in the same cycle
    step(1, 9'h1C3, 1, 1);
    check_status("R9 R10 lossy flush");
    step(0, '0, 1, 0);
    check_status("R9 empty after flush");
    step(1, 9'h077, 0, 0);
    check("R9 new head after flush", int'(pop_data), 'h077);
    step(0, '0, 1, 0);
    step(0, '0, 0, 1);
    check_status("R10 clean flush");
    // Random-ish fill/drain mix
    for (int i = 0; i < 60; i++) begin
      step(((i % 3) != 2), 9'((i * 91) + 5), ((i % 4) == 3) || (i > 40), 0);
    end
    check_status("mix");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule